// File: doc/BRIEF.md
# Prescaled Interval Timer

A 16-bit interval timer for a bus-clocked peripheral domain. A programmable divider stretches the bus clock so that the counter takes one step every (divide + 1) clocks. The counter runs upward towards the preload value or downward towards zero. When it reaches that end point it raises a sticky event flag, and it can signal an interrupt when the interrupt is enabled. With auto-restart the count wraps back and runs on. Without it the timer stops itself at the end point.

Software reaches the timer through five 32-bit word registers on a simple request/write bus with registered read data. A single control word holds the run-control bits and the divide value. Two of its bits are write-only actions: one copies the preload value into the counter, and one returns every register to its reset state one clock later.

Top module: `prescaled_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Registers sit at byte addresses 0x00 (count), 0x04 (preload), 0x08 (status), 0x0C (interrupt enable) and 0x10 (control). Count and preload keep only write bits 15:0, and their bits 31:16 read 0.
- R3: Control bits are: 0 enable, 2 direction (1 = up, 0 = down), 3 auto-restart, 4 soft reset, 5 start, 6 reload, 7 halt, and 31:16 the divide value. Bits 1 and 15:8 read 0. The reload bit reads 0.
- R4: While enable = 1, start = 1 and halt = 0, the counter takes one step every (divide + 1) clocks. The first step happens divide + 1 clocks after the control write that sets run.
- R5: Counting down, a step taken while the count is 0 sets the status flag. Without auto-restart, start clears and the count stays at 0.
- R6: Counting up, a step taken while the count equals preload sets the status flag. With auto-restart the count returns to 0 and the timer keeps running. Counting down with auto-restart, such a step loads preload instead.
- R7: With halt = 1 the count does not change.
- R8: Writing control with bit 6 set copies preload into the count at that same edge.
- R9: Status bit 0 is sticky and is cleared by writing 1 to it. Writing 0 has no effect. An end-point step in the same cycle as a clearing write leaves the flag set.
- R10: `irq_o` is high exactly when the status flag and interrupt-enable bit 0 are both 1.
- R11: Writing control with bit 4 set returns all registers to their reset values at the next edge. All other bits of that write are dropped.
- R12: A bus write to the count register in the same cycle as a counter step wins over the step.
- R13: Read data appears on `rdata_o` after the edge that samples the read request. It holds the register contents as they stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions can fall in one cycle. In the first, the clearing write to the status flag lands on the same edge as the step that sets it. The bench starts a down-count from 2 with divide 0 and times the write-1 to status onto the third step edge. It then judges the result by reading the flag back as 1 and clearing it once more. In the second, a bus write to the count lands on a running step edge. The bench reads back the written value on the next edge, and one edge later reads the value minus one, which shows that the write won and that counting went on from it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word index of each register (byte address / 4)
  localparam int unsigned IDX_CNT = 0;
  localparam int unsigned IDX_PRE = 1;
  localparam int unsigned IDX_STS = 2;
  localparam int unsigned IDX_IEN = 3;
  localparam int unsigned IDX_CTL = 4;
  localparam int unsigned NREG    = 5;

  // control word bit positions
  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_UP     = 2;
  localparam int unsigned B_AUTO   = 3;
  localparam int unsigned B_SRST   = 4;
  localparam int unsigned B_START  = 5;
  localparam int unsigned B_RELOAD = 6;
  localparam int unsigned B_HALT   = 7;
  localparam int unsigned PS_LSB   = 16;

  typedef struct packed {
    logic halt;
    logic start;
    logic autorst;
    logic up;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NREG = 5
) (
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  output logic [NREG-1:0] hit_o,
  output logic [NREG-1:0] wr_o,
  output logic            rd_o
);
  localparam int unsigned IW = AW - 2;

  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign rd_o    = req_i & ~we_i;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign hit_o[i] = aligned && (addr_i[AW-1:2] == IW'(i));
    assign wr_o[i]  = hit_o[i] & req_i & we_i;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic [PS_W-1:0] div_i,
  output logic            tick_o
);
  logic [PS_W-1:0] pcnt_q;
  logic            wrap;

  // >= so a divide value lowered mid-run cannot strand the counter
  assign wrap   = (pcnt_q >= div_i);
  assign tick_o = run_i & ~clr_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pcnt_q <= '0;
    else if (clr_i || !run_i) pcnt_q <= '0;
    else if (wrap)            pcnt_q <= '0;
    else                      pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          reload_i,
  input  logic [CW-1:0] preload_i,
  input  logic          tick_i,
  input  logic          up_i,
  input  logic          auto_i,
  output logic [CW-1:0] count_o,
  output logic          term_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end  = up_i ? (cnt_q == preload_i) : (cnt_q == '0);
  assign term_o  = tick_i & at_end;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (wr_i)     cnt_q <= wdata_i;
    else if (reload_i) cnt_q <= preload_i;
    else if (tick_i) begin
      if (at_end) begin
        if (auto_i) cnt_q <= up_i ? '0 : preload_i;
      end else begin
        cnt_q <= up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = 16,
  parameter int unsigned PS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] hit_i,
  input  logic [NREG-1:0] wr_i,
  input  logic            rd_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            term_i,
  input  logic [CW-1:0]   count_i,
  output logic [CW-1:0]   preload_o,
  output ctrl_t           ctrl_o,
  output logic [PS_W-1:0] div_o,
  output logic            srst_o,
  output logic            reload_o,
  output logic            ie_o,
  output logic            status_o,
  output logic [DW-1:0]   rdata_o
);
  logic [CW-1:0]   preload_q;
  ctrl_t           ctrl_q;
  logic [PS_W-1:0] div_q;
  logic            srst_q, ie_q, status_q;
  logic [DW-1:0]   ctl_rd, rdata_n, rdata_q;

  assign reload_o = wr_i[IDX_CTL] & wdata_i[B_RELOAD] & ~srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || srst_q) begin
      if (!rst_ni || srst_q) begin
        preload_q <= '0;
        ctrl_q    <= '0;
        div_q     <= '0;
        srst_q    <= 1'b0;
        ie_q      <= 1'b0;
        status_q  <= 1'b0;
      end
    end else begin
      if (wr_i[IDX_PRE]) preload_q <= wdata_i[CW-1:0];
      if (wr_i[IDX_IEN]) ie_q <= wdata_i[0];
      // a set from the counter outranks a software clear
      if (term_i)                             status_q <= 1'b1;
      else if (wr_i[IDX_STS] && wdata_i[0])   status_q <= 1'b0;
      if (wr_i[IDX_CTL]) begin
        ctrl_q.en      <= wdata_i[B_EN];
        ctrl_q.up      <= wdata_i[B_UP];
        ctrl_q.autorst <= wdata_i[B_AUTO];
        ctrl_q.start   <= wdata_i[B_START];
        ctrl_q.halt    <= wdata_i[B_HALT];
        div_q          <= wdata_i[PS_LSB +: PS_W];
        srst_q         <= wdata_i[B_SRST];
      end else if (term_i && !ctrl_q.autorst) begin
        ctrl_q.start <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl_rd                  = '0;
    ctl_rd[B_EN]            = ctrl_q.en;
    ctl_rd[B_UP]            = ctrl_q.up;
    ctl_rd[B_AUTO]          = ctrl_q.autorst;
    ctl_rd[B_SRST]          = srst_q;
    ctl_rd[B_START]         = ctrl_q.start;
    ctl_rd[B_HALT]          = ctrl_q.halt;
    ctl_rd[PS_LSB +: PS_W]  = div_q;
  end

  always_comb begin
    rdata_n = '0;
    if (hit_i[IDX_CNT]) rdata_n = {{(DW-CW){1'b0}}, count_i};
    if (hit_i[IDX_PRE]) rdata_n = {{(DW-CW){1'b0}}, preload_q};
    if (hit_i[IDX_STS]) rdata_n = {{(DW-1){1'b0}}, status_q};
    if (hit_i[IDX_IEN]) rdata_n = {{(DW-1){1'b0}}, ie_q};
    if (hit_i[IDX_CTL]) rdata_n = ctl_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_n;
  end

  assign preload_o = preload_q;
  assign ctrl_o    = ctrl_q;
  assign div_o     = div_q;
  assign srst_o    = srst_q;
  assign ie_o      = ie_q;
  assign status_o  = status_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int unsigned AW   = 5,
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = 16,
  parameter int unsigned PS_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [NREG-1:0] hit, wr;
  logic            rd;
  logic [CW-1:0]   preload_q, count_q;
  ctrl_t           ctrl_q;
  logic [PS_W-1:0] div_q;
  logic            srst_q, reload_stb, ie_q, status_q;
  logic            run, tick, term;

  tmr_bus_decode #(.AW(AW), .NREG(NREG)) u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .hit_o  (hit),
    .wr_o   (wr),
    .rd_o   (rd)
  );

  tmr_regs #(.DW(DW), .CW(CW), .PS_W(PS_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .wr_i      (wr),
    .rd_i      (rd),
    .wdata_i   (wdata_i),
    .term_i    (term),
    .count_i   (count_q),
    .preload_o (preload_q),
    .ctrl_o    (ctrl_q),
    .div_o     (div_q),
    .srst_o    (srst_q),
    .reload_o  (reload_stb),
    .ie_o      (ie_q),
    .status_o  (status_q),
    .rdata_o   (rdata_o)
  );

  assign run = ctrl_q.en & ctrl_q.start & ~ctrl_q.halt;

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (srst_q),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (srst_q),
    .wr_i      (wr[IDX_CNT]),
    .wdata_i   (wdata_i[CW-1:0]),
    .reload_i  (reload_stb),
    .preload_i (preload_q),
    .tick_i    (tick),
    .up_i      (ctrl_q.up),
    .auto_i    (ctrl_q.autorst),
    .count_o   (count_q),
    .term_o    (term)
  );

  assign irq_o = status_q & ie_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] count_i,
  input logic          status_i,
  input logic          halt_i,
  input logic          start_i,
  input logic          auto_i,
  input logic          srst_i,
  input logic          tick_i,
  input logic          term_i,
  input logic          cnt_wr_i,
  input logic          sts_wr_i,
  input logic          ctl_wr_i,
  input logic          reload_i,
  input logic          wbit0_i
);
  // R9: flag drops only after a write-1 clear or a soft reset
  assert_sticky_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_i) |-> $past(srst_i || (sts_wr_i && wbit0_i)));

  // R9: an end-point step always leaves the flag set
  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !srst_i) |=> status_i);

  // R4: the count moves only on a step, a bus write, a reload or a soft reset
  assert_count_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_i) |-> $past(tick_i || cnt_wr_i || reload_i || srst_i));

  // R7
  assert_halt_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !cnt_wr_i && !reload_i && !srst_i) |=> $stable(count_i));

  // R11
  assert_srst_selfclear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !srst_i);

  // R5
  assert_oneshot_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !auto_i && !ctl_wr_i && !srst_i) |=> !start_i);
endmodule

bind prescaled_timer tmr_checker #(.CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .count_i  (count_q),
  .status_i (status_q),
  .halt_i   (ctrl_q.halt),
  .start_i  (ctrl_q.start),
  .auto_i   (ctrl_q.autorst),
  .srst_i   (srst_q),
  .tick_i   (tick),
  .term_i   (term),
  .cnt_wr_i (wr[0]),
  .sts_wr_i (wr[2]),
  .ctl_wr_i (wr[4]),
  .reload_i (reload_stb),
  .wbit0_i  (wdata_i[0])
);

// File: tb/tb_prescaled_timer.sv
module tb_prescaled_timer;
  localparam logic [4:0] A_CNT = 5'h00;
  localparam logic [4:0] A_PRE = 5'h04;
  localparam logic [4:0] A_STS = 5'h08;
  localparam logic [4:0] A_IEN = 5'h0C;
  localparam logic [4:0] A_CTL = 5'h10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic rd_pend = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk_i = ~clk_i;  // 8 ns period

  prescaled_timer dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 req_i = 1'b0; we_i = 1'b0;
  endtask

  // driver: push expectation, issue read
  task automatic bus_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    @(negedge clk_i);
    e.v = exp; e.tag = tag;
    sb_q.push_back(e);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk_i);
    #1 req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk_i);
    check(irq_o === exp, tag, {31'b0, irq_o}, {31'b0, exp});
  endtask

  // monitor: R13 read data valid after the sampling edge
  always @(posedge clk_i) rd_pend <= req_i && !we_i;

  initial begin
    forever begin
      @(negedge clk_i);
      if (rd_pend) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R13 unexpected read", rdata_o, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(rdata_o === e.v, e.tag, rdata_o, e.v);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    idle(3);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    bus_rd(A_CNT, 32'h0, "R1 count");
    bus_rd(A_PRE, 32'h0, "R1 preload");
    bus_rd(A_STS, 32'h0, "R1 status");
    bus_rd(A_IEN, 32'h0, "R1 ien");
    bus_rd(A_CTL, 32'h0, "R1 ctrl");
    chk_irq(1'b0, "R1 irq");

    // R2 width masking
    bus_wr(A_PRE, 32'h0001_2345);
    bus_rd(A_PRE, 32'h0000_2345, "R2 preload upper bits");
    bus_wr(A_CNT, 32'hFFFF_0011);
    bus_rd(A_CNT, 32'h0000_0011, "R2 count upper bits");

    // R3 control readback mask
    bus_wr(A_CTL, 32'hFFFF_FF22);
    bus_rd(A_CTL, 32'hFFFF_0020, "R3 ctrl mask");
    bus_wr(A_CTL, 32'h0);

    // R8 reload strobe
    bus_wr(A_CTL, 32'h0000_0040);
    bus_rd(A_CNT, 32'h0000_2345, "R8 reload copies preload");
    bus_rd(A_CTL, 32'h0, "R8 reload reads zero");

    // R5 one-shot down count
    bus_wr(A_CNT, 32'd3);
    bus_wr(A_CTL, 32'h0000_0021);
    idle(10);
    bus_rd(A_CNT, 32'h0, "R5 stays at zero");
    bus_rd(A_STS, 32'h1, "R5 flag set");
    bus_rd(A_CTL, 32'h1, "R5 start cleared");
    chk_irq(1'b0, "R10 irq masked");

    // R10 interrupt
    bus_wr(A_IEN, 32'h1);
    bus_rd(A_IEN, 32'h1, "R10 ien readback");
    chk_irq(1'b1, "R10 irq asserted");

    // R9 write-1-to-clear
    bus_wr(A_STS, 32'h0);
    bus_rd(A_STS, 32'h1, "R9 write 0 no effect");
    bus_wr(A_STS, 32'h1);
    bus_rd(A_STS, 32'h0, "R9 write 1 clears");
    chk_irq(1'b0, "R10 irq drops");

    // R4 divide 4: steps at +5 and +10, halted at +12
    bus_wr(A_CNT, 32'd10);
    bus_wr(A_CTL, 32'h0004_0021);
    idle(11);
    bus_wr(A_CTL, 32'h0004_00A1);
    bus_rd(A_CNT, 32'd8, "R4 prescaled step count");
    idle(20);
    bus_rd(A_CNT, 32'd8, "R7 halt freezes count");
    bus_wr(A_CTL, 32'h0);

    // R11 soft reset drops the rest of the write
    bus_wr(A_PRE, 32'd3);
    bus_wr(A_CTL, 32'h0005_0031);
    idle(1);
    bus_rd(A_PRE, 32'h0, "R11 preload cleared");
    bus_rd(A_CTL, 32'h0, "R11 ctrl cleared");
    bus_rd(A_IEN, 32'h0, "R11 ien cleared");
    bus_rd(A_CNT, 32'h0, "R11 count cleared");
    chk_irq(1'b0, "R11 irq low");

    // R6 up count with auto-restart
    bus_wr(A_PRE, 32'd2);
    bus_wr(A_CTL, 32'h0000_002D);
    idle(3);
    bus_wr(A_CTL, 32'h0000_00AD);
    bus_rd(A_CNT, 32'd1, "R6 wrapped and continued");
    bus_rd(A_STS, 32'h1, "R6 flag set");
    bus_rd(A_CTL, 32'h0000_00AD, "R6 start kept");
    idle(5);
    bus_rd(A_CNT, 32'd1, "R7 halt holds up count");

    bus_wr(A_CTL, 32'h0000_0010);
    idle(1);

    // R9 collision: clear lands on the end-point step
    bus_wr(A_CNT, 32'd2);
    bus_wr(A_CTL, 32'h0000_0021);
    idle(2);
    bus_wr(A_STS, 32'h1);
    bus_rd(A_STS, 32'h1, "R9 set wins over clear");
    bus_wr(A_STS, 32'h1);
    bus_rd(A_STS, 32'h0, "R9 later clear");

    // R12 bus write beats a running step
    bus_wr(A_PRE, 32'd5);
    bus_wr(A_CTL, 32'h0000_0029);
    idle(3);
    bus_wr(A_CNT, 32'h00FF_0064);
    bus_rd(A_CNT, 32'd100, "R12 write wins");
    bus_rd(A_CNT, 32'd99, "R13 read shows pre-edge value");

    idle(4);
    while (sb_q.size() != 0) @(negedge clk_i);
    done = 1'b1;
    finish_run();
  end
endmodule